// File: doc/BRIEF.md
# Dual-Mode ADC Serial Result Framer

This block is the digital back end of a 14-bit sampling converter. A falling edge on the active-low convert-start input begins a conversion that occupies the sequencer for 24 master-clock cycles. The converted value comes from a behavioural result port that carries a signed sample. The block folds that sample into a 14-bit straight-binary code plus an overrange flag. Because every bit trial has to finish before a result is formed, each code is released one sample late. The frames sent out after conversion N therefore carry the result of conversion N-1.

Results leave on a serial clock that runs at half the master-clock rate and on a data line with an output enable, which models the high-impedance state. Each frame is 16 bits long. A mode-select input picks what frames the data. With mode select low, the low period of convert-start is the frame. With mode select high, the frame-sync input is the frame and the convert-start duty cycle is free. An active-low reset aborts any conversion, clears the stored results and holds every output idle.

Top module: `adc_frame_serializer`

## Requirements
- R1: A conversion is accepted on a convert-start falling edge seen at a master-clock edge while idle, and occupies the sequencer for 24 cycles. A falling edge seen 25 or more edges after the accepting edge is accepted.
- R2: Frames carry the result of the conversion before the most recently accepted one: the output lags the sampled input by exactly one accepted conversion.
- R3: A frame is 16 bits on the data line: the overrange flag first, then the 14 code bits MSB first, then one zero bit. The data line reads zero after that for as long as the frame stays open.
- R4: A sample below zero gives code 0 with overrange 1. A sample above 16383 gives code 16383 with overrange 1. A sample from 0 to 16383 gives that value in straight binary with overrange 0.
- R5: The serial clock toggles on every master-clock edge. The data line changes inside a frame only on a serial-clock rising edge. The first bit appears on the first rising edge after the output enable rises.
- R6: With mode select 0, the output enable follows the inverted convert-start input one master-clock cycle later, and frame-sync has no effect.
- R7: With mode select 1, the output enable follows the inverted frame-sync input one master-clock cycle later, and a convert-start pulse does not enable the output.
- R8: While reset is low, the output enable and serial clock are 0, any running conversion is abandoned and both stored results are cleared.
- R9: When a frame closes before 16 bits, the output enable drops one cycle later, the remaining bits are lost and the stored result is unchanged for the next frame.
- R10: Before any conversion completes after reset, frames carry an all-zero word.
- R11: A convert-start falling edge during a running conversion is ignored and never becomes a result.
- R12: While the output enable is low the data line is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_n | input | 1 | Active-low convert-start; falling edge starts a conversion, low level frames data in mode 0 |
| mode_sel | input | 1 | Framing source: 0 convert-start, 1 frame-sync |
| fsync_n | input | 1 | Active-low frame-sync, frames data in mode 1 |
| smp_val | input | 16 | Signed behavioural sample captured when a conversion is accepted |
| sclk | output | 1 | Serial clock, half the master-clock rate |
| sdo | output | 1 | Serial data, changes on serial-clock rising edges |
| sdo_oe | output | 1 | Serial data output enable; low means high impedance |

## Verification
Samples at both rails, just past each rail and with alternating bit patterns expose a wrong fold, a swapped bit order or a missing trailing zero. Runs of back-to-back conversions in both framing modes show whether the one-sample lag holds, and whether the idle framing input is ignored. Convert-start edges placed exactly 24 and 25 edges after an accepted start separate a busy window that is too short from one that is too long. A frame cut short, and a reset during a conversion, show that stored results survive a cut frame but not a reset.

// File: rtl/adc_fr_pkg.sv
package adc_fr_pkg;

  // framing source chosen by the mode-select pin
  typedef enum logic {
    SRC_CONVERT = 1'b0,
    SRC_FSYNC   = 1'b1
  } frame_src_e;

endpackage

// File: rtl/adcf_sclk_gen.sv
module adcf_sclk_gen (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_next
);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= ~sclk_q;
  end

  assign sclk      = sclk_q;
  // the coming master-clock edge is a serial-clock rising edge
  assign rise_next = ~sclk_q;

endmodule

// File: rtl/adcf_conv_seq.sv
module adcf_conv_seq #(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned IN_W     = DATA_W + 2,
  parameter int unsigned CONV_CYC = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_edge,
  input  logic signed [IN_W-1:0] smp_val,
  output logic                   busy,
  output logic [DATA_W:0]        rd_word
);

  localparam int unsigned CW = $clog2(CONV_CYC);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);
  localparam logic signed [IN_W-1:0] FULL = IN_W'((1 << DATA_W) - 1);

  // signed sample -> {overrange, straight-binary code}
  function automatic logic [DATA_W:0] fold_sample(input logic signed [IN_W-1:0] v);
    logic [DATA_W:0] r;
    if (v[IN_W-1])    r = {1'b1, {DATA_W{1'b0}}};
    else if (v > FULL) r = {1'b1, {DATA_W{1'b1}}};
    else               r = {1'b0, v[DATA_W-1:0]};
    return r;
  endfunction

  logic [CW-1:0]   cnt_q;
  logic [DATA_W:0] hold_q;
  logic [DATA_W:0] done_q;
  logic [DATA_W:0] out_q;
  logic            busy_q;
  logic            accept;

  assign accept = start_edge & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      done_q <= '0;
      out_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= hold_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      hold_q <= fold_sample(smp_val);
      // the previous result is released only now: one sample of lag
      out_q  <= done_q;
    end
  end

  assign busy    = busy_q;
  assign rd_word = out_q;

endmodule

// File: rtl/adcf_shifter.sv
module adcf_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fr_req,
  input  logic               rise_next,
  input  logic [FRAME_W-1:0] word,
  output logic               sdo,
  output logic               sdo_oe
);

  localparam int unsigned BW = $clog2(FRAME_W + 1);
  localparam logic [BW-1:0] NBITS = BW'(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [BW-1:0]      cnt_q;
  logic               oe_q;
  logic               sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      sdo_q <= 1'b0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      oe_q <= fr_req;
      if (!fr_req) begin
        sdo_q <= 1'b0;
        cnt_q <= '0;
      end else if (oe_q && rise_next) begin
        if (cnt_q == '0) begin
          // word is taken at the first bit, after any release of a result
          sdo_q <= word[FRAME_W-1];
          sh_q  <= {word[FRAME_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
        end else if (cnt_q < NBITS) begin
          sdo_q <= sh_q[FRAME_W-1];
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer
  import adc_fr_pkg::*;
#(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned IN_W     = DATA_W + 2,
  parameter int unsigned CONV_CYC = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnv_n,
  input  logic                   mode_sel,
  input  logic                   fsync_n,
  input  logic signed [IN_W-1:0] smp_val,
  output logic                   sclk,
  output logic                   sdo,
  output logic                   sdo_oe
);

  localparam int unsigned FRAME_W = DATA_W + 2;

  logic               cnv_q;
  logic               cnv_fall;
  logic               fr_req;
  logic               rise_next;
  logic               conv_busy;
  logic [DATA_W:0]    rd_word;
  logic [FRAME_W-1:0] frame_word;
  frame_src_e         src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnv_q <= 1'b1;
    else        cnv_q <= cnv_n;
  end

  assign cnv_fall   = cnv_q & ~cnv_n;
  assign src        = frame_src_e'(mode_sel);
  assign fr_req     = (src == SRC_FSYNC) ? ~fsync_n : ~cnv_n;
  assign frame_word = {rd_word, 1'b0};

  adcf_sclk_gen u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .rise_next (rise_next)
  );

  adcf_conv_seq #(
    .DATA_W   (DATA_W),
    .IN_W     (IN_W),
    .CONV_CYC (CONV_CYC)
  ) u_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_edge (cnv_fall),
    .smp_val    (smp_val),
    .busy       (conv_busy),
    .rd_word    (rd_word)
  );

  adcf_shifter #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .fr_req    (fr_req),
    .rise_next (rise_next),
    .word      (frame_word),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

endmodule

// File: rtl/adcf_checker.sv
module adcf_checker (
  input logic clk,
  input logic rst_n,
  input logic cnv_n,
  input logic mode_sel,
  input logic fsync_n,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe,
  input logic busy
);

  // R1
  conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cnv_n));

  // R5
  sdo_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> $rose(sclk));

  // R6
  mode0_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |=> (sdo_oe == !$past(cnv_n)));

  // R7
  mode1_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |=> (sdo_oe == !$past(fsync_n)));

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!sdo_oe && !sclk));

  // R12
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

endmodule

bind adc_frame_serializer adcf_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnv_n    (cnv_n),
  .mode_sel (mode_sel),
  .fsync_n  (fsync_n),
  .sclk     (sclk),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .busy     (conv_busy)
);

// File: tb/test_adc_frame_serializer.sv
module test_adc_frame_serializer;
  localparam int DW = 14;
  localparam int IW = 16;
  localparam int FW = 16;
  localparam int CONV = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cnv_n = 1'b1;
  logic mode_sel = 1'b0;
  logic fsync_n = 1'b1;
  logic signed [IW-1:0] smp_val = '0;
  logic sclk, sdo, sdo_oe;

  adc_frame_serializer i_adc_frame_serializer (
    .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .mode_sel(mode_sel),
    .fsync_n(fsync_n), .smp_val(smp_val), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model of the stored results
  logic [DW:0] m_done = '0, m_out = '0, m_pend = '0;
  bit m_pend_v = 0, m_have_go = 0;
  int m_last_go = 0;

  logic [FW-1:0] exp_q[$];
  string tag_q[$];
  int short_cnt = 0;

  function automatic logic [DW:0] ref_fold(int v);
    logic [DW:0] r;
    if (v < 0) r = 15'h4000;
    else if (v > 16383) r = 15'h7fff;
    else r = {1'b0, v[DW-1:0]};
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic model_fall(int det, int v);
    if (!m_have_go || det >= m_last_go + CONV + 1) begin
      if (m_pend_v) m_done = m_pend;
      m_out = m_done;
      m_pend = ref_fold(v);
      m_pend_v = 1;
      m_have_go = 1;
      m_last_go = det;
    end
  endtask

  task automatic model_reset();
    m_done = '0; m_out = '0; m_pend = '0; m_pend_v = 0; m_have_go = 0;
  endtask

  // called just after a negedge; falling edge is seen at posedge det
  task automatic pulse_at(int det, int v);
    while (cyc < det - 1) @(negedge clk);
    smp_val = IW'(v);
    cnv_n = 1'b0;
    model_fall(cyc + 1, v);
    @(negedge clk);
    cnv_n = 1'b1;
  endtask

  task automatic pulse_cnv(int v);
    @(negedge clk);
    pulse_at(cyc + 1, v);
  endtask

  task automatic read_m2(string tag);
    @(negedge clk);
    fsync_n = 1'b0;
    exp_q.push_back({m_out, 1'b0});
    tag_q.push_back(tag);
    @(negedge clk);
    check(sdo_oe == 1'b1, "R7", "enable after frame-sync low", int'(sdo_oe), 1);
    repeat (37) @(negedge clk);
    fsync_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic conv_m1(int v, string tag);
    @(negedge clk);
    smp_val = IW'(v);
    cnv_n = 1'b0;
    model_fall(cyc + 1, v);
    exp_q.push_back({m_out, 1'b0});
    tag_q.push_back(tag);
    @(negedge clk);
    check(sdo_oe == 1'b1, "R6", "enable after convert-start low", int'(sdo_oe), 1);
    repeat (37) @(negedge clk);
    cnv_n = 1'b1;
    @(negedge clk);
    check(sdo_oe == 1'b0, "R6", "enable after convert-start high", int'(sdo_oe), 0);
    repeat (2) @(negedge clk);
  endtask

  // monitor: collects bits on serial-clock rising edges, compares frames
  logic prev_oe = 1'b0, prev_sclk = 1'b0, prev_sdo = 1'b0;
  int nbits = 0;
  logic [FW-1:0] word = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0;
    end else begin
      if (sdo_oe && prev_oe && sdo !== prev_sdo)
        check(sclk && !prev_sclk, "R5", "data change off rising edge", int'(sclk), 1);
      if (sdo_oe && prev_oe && sclk && !prev_sclk) begin
        if (nbits < FW) begin
          word = {word[FW-2:0], sdo};
          nbits++;
        end else begin
          check(sdo == 1'b0, "R3", "line after trailing bit", int'(sdo), 0);
        end
      end
      if (!sdo_oe)
        check(sdo == 1'b0, "R12", "data while disabled", int'(sdo), 0);
      if (!sdo_oe && prev_oe) begin
        if (nbits == FW) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected frame", int'(word), 0);
          end else begin
            logic [FW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(word == e, t, "frame word", int'(word), int'(e));
          end
        end else begin
          short_cnt++;
        end
        nbits = 0;
      end
    end
    prev_oe = sdo_oe;
    prev_sclk = sclk;
    prev_sdo = sdo;
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, sc, g, h;
    repeat (3) @(negedge clk);
    check(sdo_oe == 1'b0, "R8", "enable in reset", int'(sdo_oe), 0);
    check(sclk == 1'b0, "R8", "serial clock in reset", int'(sclk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    s0 = int'(sclk);
    @(negedge clk);
    check(int'(sclk) != s0, "R5", "serial clock toggles", int'(sclk), 1 - s0);

    // mode 0: convert-start frames the data
    mode_sel = 1'b0;
    conv_m1(100, "R10");
    conv_m1(16383, "R2");
    conv_m1(-5, "R4");
    conv_m1(16384, "R4");
    conv_m1(16'h2AAA, "R4");
    conv_m1(16'h1555, "R3");
    conv_m1(0, "R3");

    @(negedge clk);
    fsync_n = 1'b0;
    repeat (4) @(negedge clk);
    check(sdo_oe == 1'b0, "R6", "frame-sync ignored in mode 0", int'(sdo_oe), 0);
    fsync_n = 1'b1;
    repeat (2) @(negedge clk);

    // mode 1: frame-sync frames the data
    mode_sel = 1'b1;
    pulse_cnv(30000);
    @(negedge clk);
    check(sdo_oe == 1'b0, "R7", "convert-start ignored in mode 1", int'(sdo_oe), 0);
    repeat (30) @(negedge clk);
    pulse_cnv(16'h0F0F);
    repeat (2) @(negedge clk);
    read_m2("R7");

    // short frame
    sc = short_cnt;
    @(negedge clk);
    fsync_n = 1'b0;
    repeat (12) @(negedge clk);
    fsync_n = 1'b1;
    @(negedge clk);
    check(sdo_oe == 1'b0, "R9", "enable after early close", int'(sdo_oe), 0);
    repeat (2) @(negedge clk);
    check(short_cnt == sc + 1, "R9", "short frame seen", short_cnt, sc + 1);
    read_m2("R9");

    // start during a running conversion
    repeat (30) @(negedge clk);
    g = cyc + 2;
    pulse_at(g, 1234);
    pulse_at(g + 24, 4321);
    pulse_at(g + 40, 77);
    repeat (2) @(negedge clk);
    read_m2("R11");
    pulse_cnv(55);
    repeat (2) @(negedge clk);
    read_m2("R11");

    // earliest accepted restart
    h = cyc + 30;
    pulse_at(h, 500);
    pulse_at(h + 25, 600);
    repeat (2) @(negedge clk);
    read_m2("R1");

    // reset during a conversion
    repeat (30) @(negedge clk);
    pulse_cnv(900);
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check(sdo_oe == 1'b0 && sclk == 1'b0, "R8", "outputs idle in reset",
          int'({sdo_oe, sclk}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    read_m2("R10");
    pulse_cnv(2000);
    repeat (30) @(negedge clk);
    pulse_cnv(3000);
    repeat (2) @(negedge clk);
    read_m2("R8");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R3", "frames outstanding", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule